// File: doc/BRIEF.md
# I/O Instruction Handshake Sequencer

This block is the processor-side controller that carries one peripheral I/O instruction across a shared I/O bus. A decoded instruction comes in: its class (command, test or output transfer), a wait flag, a device number and the data word that goes with it. The sequencer counts the timing slots of the instruction cycle and raises a sync strobe toward the addressed unit at a fixed slot. It then holds the instruction cycle until the unit returns a sync acknowledge. From the unit's test line it decides whether the next instruction is skipped, and it drives a data strobe while the data word is on the bus. It finishes with a one-cycle completion that reports a program-counter step of one or two.

The instruction enters on a valid/ready pair. `instr_ready` is high only while the sequencer is idle, and a word is taken on the rising edge where valid and ready are both high. The source must hold the fields stable until that edge. Once taken, the fields are held inside the block until completion, so the source may change them freely afterwards. There is no back-pressure on the completion side: `done` is a single-cycle pulse that must be consumed when it appears.

Memory timing, interrupt servicing and indirect addressing are outside the block. They appear only as the hold indication, which stretches the instruction cycle, and as an interrupt gate that lets only the critical sources through while a wait-mode instruction is stalled. A cycle watchdog ends any handshake that never completes and reports a bus fault.

Top module: `io_handshake_seq`

## Requirements
- R1: `instr_ready` is 1 only in the idle state. A word is accepted when `instr_valid` and `instr_ready` are both high at a rising edge, and `instr_valid` has no effect while the block is busy.
- R2: The slot counter reads 1 after the accepting edge and advances by one per clock. `sync_strobe` goes high when the counter reaches `SYNC_SLOT` (default 5), which is `SYNC_SLOT`-1 edges after acceptance, and it stays high until the sync acknowledge is taken.
- R3: Once the sync strobe is up, `icyc_hold` is 1 and no completion occurs until `sync_ack` is accepted. `sync_strobe` drops on the edge that accepts it.
- R4: For the command (class 2'b00) and output (class 2'b10) classes, `pc_step` is 2 if `test_ok` was high together with the accepted `sync_ack`, and 1 otherwise.
- R5: For command and output classes with `test_ok` low at the accepted `sync_ack`, `data_strobe` is never raised, and `done` appears on the next cycle.
- R6: `data_strobe` rises on the edge after sync acceptance. It stays high with `io_bus` equal to the held data word until `data_ack` is seen. `io_bus` is zero whenever `data_strobe` is low.
- R7: For the test class (2'b01), `data_strobe` is raised after sync acceptance regardless of `test_ok`. `pc_step` is 2 if `test_ok` is high together with `data_ack`, else 1. The wait flag and `test_ok` at sync time have no effect.
- R8: For command or output with the wait flag set, a `sync_ack` with `test_ok` low is not accepted. The block stays in the hold state with `sync_strobe` high.
- R9: While a wait-mode command or output is held, `irq_grant` = `irq_req` & `CRIT_MASK` and `irq_inhibit` is 1. At all other times `irq_grant` = `irq_req` and `irq_inhibit` is 0.
- R10: `dev_sel` is the one-hot decode of the held device number from acceptance up to completion, and zero while idle or completing.
- R11: If a wait for `sync_ack` or `data_ack` lasts `TIMEOUT` cycles, the block completes with `bus_fault` = 1 and `pc_step` = 1, and both strobes drop.
- R12: After reset, `instr_ready` = 1 and `sync_strobe`, `data_strobe`, `done`, `bus_fault`, `dev_sel` and `io_bus` are all zero.
- R13: `done` is high for exactly one cycle per instruction, and `instr_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Sequencer idle, can accept |
| instr_class | input | 2 | 00 command, 01 test, 10 output |
| instr_wait | input | 1 | Wait-mode flag |
| instr_dev | input | DEVW | Device number |
| instr_data | input | DW | Second word or output data |
| sync_strobe | output | 1 | Instruction sync to unit |
| dev_sel | output | NDEV | One-hot unit select |
| sync_ack | input | 1 | Unit sync return |
| test_ok | input | 1 | Unit ready / test-true line |
| data_ack | input | 1 | Unit accepted data |
| data_strobe | output | 1 | Data-here strobe |
| io_bus | output | DW | Data word on bus |
| icyc_hold | output | 1 | Instruction cycle held |
| irq_req | input | NIRQ | Pending interrupt sources |
| irq_inhibit | output | 1 | Normal interrupts blocked |
| irq_grant | output | NIRQ | Interrupt sources permitted |
| done | output | 1 | Instruction complete (1 cycle) |
| pc_step | output | 2 | Program counter advance, 1 or 2 |
| bus_fault | output | 1 | Completion due to timeout |

## Verification
A wrong state register makes itself seen at the ports within one cycle. A sync strobe that rises at the wrong slot, or that lingers after the acknowledge, or a data strobe that appears for an unready command, each shows on the next sampled clock. A wrong skip decision shows only in `pc_step` during the single completion cycle, so that value is checked for every instruction against a model of the class, the readiness and the test result. A faulty hold or watchdog count shows as a completion arriving too early or too late, and the bench measures it to the exact cycle.

// File: rtl/iohs_pkg.sv
package iohs_pkg;

  typedef enum logic [1:0] {
    CLS_CMD  = 2'b00,
    CLS_TEST = 2'b01,
    CLS_OUT  = 2'b10,
    CLS_RSV  = 2'b11
  } iocls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ICYC,
    ST_SYNC,
    ST_DATA,
    ST_FIN
  } seq_st_e;

  localparam logic [1:0] STEP_ONE = 2'd1;
  localparam logic [1:0] STEP_TWO = 2'd2;

endpackage

// File: rtl/iohs_slot_timer.sv
// Counts timing slots within the instruction cycle; flags the sync slot.
module iohs_slot_timer #(
  parameter int NSLOT     = 16,
  parameter int SYNC_SLOT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic at_sync
);
  localparam int SW = $clog2(NSLOT + 1);
  localparam logic [SW-1:0] LAST = SW'(NSLOT);
  localparam logic [SW-1:0] SYNC = SW'(SYNC_SLOT);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   slot_q <= '0;
    else if (start)               slot_q <= SW'(1);
    else if (run && slot_q != LAST) slot_q <= slot_q + SW'(1);
  end

  assign at_sync = (slot_q == SYNC);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST); // R2

endmodule

// File: rtl/iohs_dev_decode.sv
// One-hot decode of the held device number.
module iohs_dev_decode #(
  parameter int NDEV = 8,
  parameter int DEVW = $clog2(NDEV)
) (
  input  logic [DEVW-1:0] dev_idx,
  input  logic            en,
  output logic [NDEV-1:0] sel_o
);
  for (genvar i = 0; i < NDEV; i++) begin : g_sel
    assign sel_o[i] = en && (dev_idx == DEVW'(i));
  end
endmodule

// File: rtl/iohs_watchdog.sv
// Counts cycles spent in a handshake wait; expires after TIMEOUT cycles.
module iohs_watchdog #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clr,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!active || clr)  cnt_q <= '0;
    else if (cnt_q != LIM)    cnt_q <= cnt_q + CW'(1);
  end

  assign expire = active && (cnt_q == LIM);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R11

endmodule

// File: rtl/io_handshake_seq.sv
module io_handshake_seq
  import iohs_pkg::*;
#(
  parameter int DW        = 16,
  parameter int NDEV      = 8,
  parameter int DEVW      = $clog2(NDEV),
  parameter int NSLOT     = 16,
  parameter int SYNC_SLOT = 5,
  parameter int TIMEOUT   = 1024,
  parameter int NIRQ      = 4,
  parameter logic [NIRQ-1:0] CRIT_MASK = 4'b1100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [1:0]      instr_class,
  input  logic            instr_wait,
  input  logic [DEVW-1:0] instr_dev,
  input  logic [DW-1:0]   instr_data,
  output logic            sync_strobe,
  output logic [NDEV-1:0] dev_sel,
  input  logic            sync_ack,
  input  logic            test_ok,
  input  logic            data_ack,
  output logic            data_strobe,
  output logic [DW-1:0]   io_bus,
  output logic            icyc_hold,
  input  logic [NIRQ-1:0] irq_req,
  output logic            irq_inhibit,
  output logic [NIRQ-1:0] irq_grant,
  output logic            done,
  output logic [1:0]      pc_step,
  output logic            bus_fault
);

  seq_st_e         state_q, state_d;
  iocls_e          cls_q;
  logic            wait_q;
  logic [DEVW-1:0] dev_q;
  logic [DW-1:0]   data_q;
  logic [1:0]      step_q, step_d;
  logic            fault_q, fault_d;

  logic accept, is_test, sync_release, go_data, at_sync, wd_expire, wd_active;

  assign instr_ready  = (state_q == ST_IDLE);
  assign accept       = instr_valid && instr_ready;
  assign is_test      = (cls_q == CLS_TEST);
  assign sync_release = (state_q == ST_SYNC) && sync_ack && (is_test || !wait_q || test_ok);
  assign go_data      = is_test || test_ok;
  assign wd_active    = (state_q == ST_SYNC) || (state_q == ST_DATA);

  iohs_slot_timer #(.NSLOT(NSLOT), .SYNC_SLOT(SYNC_SLOT)) u_slot (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .run(state_q == ST_ICYC), .at_sync(at_sync));

  iohs_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk(clk), .rst_n(rst_n), .active(wd_active),
    .clr(sync_release), .expire(wd_expire));

  iohs_dev_decode #(.NDEV(NDEV), .DEVW(DEVW)) u_dec (
    .dev_idx(dev_q),
    .en((state_q == ST_ICYC) || wd_active),
    .sel_o(dev_sel));

  // next-state and completion result
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_ICYC;
        fault_d = 1'b0;
      end
      ST_ICYC: if (at_sync) state_d = ST_SYNC;
      ST_SYNC: begin
        if (sync_release) begin
          if (go_data) state_d = ST_DATA;
          else begin
            state_d = ST_FIN;
            step_d  = STEP_ONE;
          end
        end else if (wd_expire) begin
          state_d = ST_FIN;
          step_d  = STEP_ONE;
          fault_d = 1'b1;
        end
      end
      ST_DATA: begin
        if (data_ack) begin
          state_d = ST_FIN;
          step_d  = (!is_test || test_ok) ? STEP_TWO : STEP_ONE;
        end else if (wd_expire) begin
          state_d = ST_FIN;
          step_d  = STEP_ONE;
          fault_d = 1'b1;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_CMD;
      wait_q  <= 1'b0;
      dev_q   <= '0;
      data_q  <= '0;
      step_q  <= STEP_ONE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      fault_q <= fault_d;
      if (accept) begin
        cls_q  <= iocls_e'(instr_class);
        wait_q <= instr_wait;
        dev_q  <= instr_dev;
        data_q <= instr_data;
      end
    end
  end

  assign sync_strobe = ((state_q == ST_ICYC) && at_sync) || (state_q == ST_SYNC);
  assign icyc_hold   = (state_q == ST_SYNC);
  assign data_strobe = (state_q == ST_DATA);
  assign io_bus      = data_strobe ? data_q : '0;
  assign irq_inhibit = (state_q == ST_SYNC) && wait_q && !is_test;
  assign irq_grant   = irq_inhibit ? (irq_req & CRIT_MASK) : irq_req;
  assign done        = (state_q == ST_FIN);
  assign pc_step     = step_q;
  assign bus_fault   = done && fault_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC) && !sync_ack && !wd_expire |=> sync_strobe && !done); // R3
  AST_WAIT_RETEST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC) && wait_q && !is_test && !test_ok && !wd_expire |=> sync_strobe); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe && !data_ack && !wd_expire |=> data_strobe && $stable(io_bus)); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_strobe && data_strobe)); // R5
  AST_GRANT_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inhibit |-> (irq_grant & ~CRIT_MASK) == '0); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && instr_ready); // R13
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_step == STEP_ONE) || (pc_step == STEP_TWO)); // R4
  AST_FAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |-> (pc_step == STEP_ONE) && !data_strobe && !sync_strobe); // R11

endmodule

// File: tb/tb_io_handshake_seq.sv
`timescale 1ns/1ps
module tb_io_handshake_seq;
  localparam int DW = 16, NDEV = 8, DEVW = 3, SYNC_SLOT = 5, TO = 24, NIRQ = 4;
  localparam logic [NIRQ-1:0] CRIT = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 0, instr_wait = 0, sync_ack = 0, test_ok = 0, data_ack = 0;
  logic [1:0] instr_class = 0;
  logic [DEVW-1:0] instr_dev = 0;
  logic [DW-1:0] instr_data = 0;
  logic [NIRQ-1:0] irq_req = 0;
  logic instr_ready, sync_strobe, data_strobe, icyc_hold, irq_inhibit, done, bus_fault;
  logic [NDEV-1:0] dev_sel;
  logic [DW-1:0] io_bus;
  logic [NIRQ-1:0] irq_grant;
  logic [1:0] pc_step;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  io_handshake_seq #(.DW(DW), .NDEV(NDEV), .DEVW(DEVW), .SYNC_SLOT(SYNC_SLOT),
                     .TIMEOUT(TO), .NIRQ(NIRQ), .CRIT_MASK(CRIT)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_class(instr_class), .instr_wait(instr_wait), .instr_dev(instr_dev),
    .instr_data(instr_data), .sync_strobe(sync_strobe), .dev_sel(dev_sel),
    .sync_ack(sync_ack), .test_ok(test_ok), .data_ack(data_ack),
    .data_strobe(data_strobe), .io_bus(io_bus), .icyc_hold(icyc_hold),
    .irq_req(irq_req), .irq_inhibit(irq_inhibit), .irq_grant(irq_grant),
    .done(done), .pc_step(pc_step), .bus_fault(bus_fault));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_step(input int cls, input bit rdy, input bit res);
    if (cls == 1) return res ? 2 : 1;
    return rdy ? 2 : 1;
  endfunction

  function automatic bit exp_data(input int cls, input bit rdy);
    return (cls == 1) || rdy;
  endfunction

  function automatic int exp_grant(input int req, input bit inh);
    return inh ? (req & int'(CRIT)) : req;
  endfunction

  // one instruction; rdy = unit ready at sync, res = test result, poke = offer a 2nd word while busy
  task automatic run_instr(input int cls, input bit wt, input int dev, input int data,
                           input bit rdy, input bit res, input int d1, input int d2,
                           input bit poke);
    bit inh, eff_rdy;
    inh = wt && (cls != 1);
    eff_rdy = inh ? 1'b1 : rdy;
    @(negedge clk);
    instr_valid = 1; instr_class = 2'(cls); instr_wait = wt;
    instr_dev = DEVW'(dev); instr_data = DW'(data);
    check(instr_ready == 1, "R1 ready idle", int'(instr_ready), 1);
    @(negedge clk);
    instr_valid = 0; instr_dev = '0; instr_data = '0;
    check(instr_ready == 0, "R1 ready busy", int'(instr_ready), 0);
    check(sync_strobe == 0, "R2 sync early", int'(sync_strobe), 0);
    for (int k = 2; k <= SYNC_SLOT; k++) begin
      @(negedge clk);
      check(sync_strobe == (k == SYNC_SLOT), "R2 sync slot", int'(sync_strobe), int'(k == SYNC_SLOT));
    end
    check(dev_sel == NDEV'(1 << dev), "R10 dev_sel", int'(dev_sel), 1 << dev);
    @(negedge clk);
    check(icyc_hold == 1, "R3 hold", int'(icyc_hold), 1);
    check(int'(irq_grant) == exp_grant(int'(irq_req), inh), "R9 grant", int'(irq_grant),
          exp_grant(int'(irq_req), inh));
    check(irq_inhibit == inh, "R9 inhibit", int'(irq_inhibit), int'(inh));
    if (inh) begin sync_ack = 1; test_ok = 0; end
    if (poke) begin
      instr_valid = 1; instr_dev = DEVW'(dev + 1); instr_data = ~DW'(data);
    end
    for (int k = 0; k < d1; k++) begin
      @(negedge clk);
      check(sync_strobe == 1 && done == 0, inh ? "R8 wait retest" : "R3 stall",
            int'(sync_strobe), 1);
    end
    sync_ack = 1;
    test_ok = (cls == 1) ? 1'($urandom_range(1)) : eff_rdy;
    @(negedge clk);
    sync_ack = 0; test_ok = 0; instr_valid = 0;
    check(sync_strobe == 0, "R3 sync drop", int'(sync_strobe), 0);
    if (exp_data(cls, eff_rdy)) begin
      check(data_strobe == 1, cls == 1 ? "R7 test strobe" : "R6 strobe", int'(data_strobe), 1);
      check(io_bus == DW'(data), "R6 bus data", int'(io_bus), data);
      check(dev_sel == NDEV'(1 << dev), "R1 held dev", int'(dev_sel), 1 << dev);
      for (int k = 0; k < d2; k++) begin
        @(negedge clk);
        check(data_strobe == 1 && done == 0, "R6 held", int'(data_strobe), 1);
      end
      data_ack = 1; test_ok = (cls == 1) ? res : 1'($urandom_range(1));
      @(negedge clk);
      data_ack = 0; test_ok = 0;
      check(data_strobe == 0 && io_bus == 0, "R6 release", int'(io_bus), 0);
    end else begin
      check(data_strobe == 0, "R5 no strobe", int'(data_strobe), 0);
    end
    check(done == 1 && bus_fault == 0, "R13 done", int'(done), 1);
    check(int'(pc_step) == exp_step(cls, eff_rdy, res), cls == 1 ? "R7 step" : "R4 step",
          int'(pc_step), exp_step(cls, eff_rdy, res));
    @(negedge clk);
    check(done == 0 && instr_ready == 1, "R13 pulse", int'(done), 0);
    check(dev_sel == 0, "R10 idle sel", int'(dev_sel), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedv, n;
    seedv = $urandom(32'h5eed);
    irq_req = 4'b1111;
    repeat (3) @(negedge clk);
    check(instr_ready == 1 && sync_strobe == 0 && data_strobe == 0 && done == 0,
          "R12 reset ctl", int'(instr_ready), 1);
    check(dev_sel == 0 && io_bus == 0 && bus_fault == 0, "R12 reset data", int'(io_bus), 0);
    rst_n = 1;
    @(negedge clk);
    check(irq_grant == irq_req, "R9 idle grant", int'(irq_grant), int'(irq_req));

    // directed corners
    run_instr(0, 0, 3, 16'h1234, 1, 0, 0, 0, 0);   // command ready, skip
    run_instr(2, 0, 5, 16'hBEEF, 0, 0, 2, 0, 0);   // output not ready, no strobe
    run_instr(2, 1, 7, 16'hA5A5, 0, 0, 3, 2, 1);   // wait-mode retest, busy offer ignored
    run_instr(1, 1, 0, 16'h0F0F, 0, 0, 1, 3, 0);   // test false, wait ignored
    run_instr(1, 0, 6, 16'hF00D, 0, 1, 0, 0, 0);   // test true

    // timeout: no sync acknowledge ever
    @(negedge clk);
    instr_valid = 1; instr_class = 2'd0; instr_wait = 0; instr_dev = 3'd2;
    @(negedge clk);
    instr_valid = 0;
    n = 1;
    while (!done && n < 100) begin @(negedge clk); n++; end
    check(n == SYNC_SLOT + 1 + TO, "R11 timeout time", n, SYNC_SLOT + 1 + TO);
    check(bus_fault == 1 && pc_step == 1, "R11 fault", int'(pc_step), 1);
    check(sync_strobe == 0 && data_strobe == 0, "R11 strobes", int'(sync_strobe), 0);
    @(negedge clk);

    // random mix
    for (int i = 0; i < 60; i++) begin
      irq_req = 4'($urandom_range(15));
      run_instr(int'($urandom_range(2)), 1'($urandom_range(1)), int'($urandom_range(NDEV - 1)),
                int'($urandom_range(16'hFFFF)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                int'($urandom_range(4)), int'($urandom_range(4)), 1'($urandom_range(1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule